// File: doc/BRIEF.md
# Fully Associative LRU Hit/Miss Tracker

This block keeps the tag bookkeeping of a fully associative cache that replaces its least recently used line. It holds no data. Each access drops the byte-offset bits from the address, and the remaining group address serves as the whole tag. That tag is compared against every valid entry at once. The block reports a one-cycle hit or miss pulse and keeps running hit and miss totals.

On a miss, a free entry is chosen before any eviction. The free entry used is always the lowest-numbered one with a clear valid bit. Only when every entry is occupied is the least recently used entry replaced. Recency is held as an ordered list of entry numbers, with the most recent entry first. Every access, hit or fill, moves the touched entry to the head of the list.

A dump port, addressed by entry number, shows whether an entry is valid and which access address touched it last. The entry count and the block size are power-of-two parameters.

Top module: `fa_lru_tracker`

## Requirements
- R1: The tag of an access is access_addr_i shifted right by log2(BLOCK_BYTES). Any two addresses inside the same block share one tag, so with 8-byte blocks a lookup of 31 hits after 24 has been filled, and a lookup of 32 does not.
- R2: In the cycle after an edge that samples access_valid_i high, exactly one of hit_o and miss_o is high, and for one cycle only. hit_o means that some valid entry held the tag.
- R3: On a miss, when at least one entry is invalid, the lowest-numbered invalid entry is filled. From reset, with 4 entries and 8-byte blocks, address 24 misses and lands in entry 0.
- R4: On a miss with every entry valid, the least recently used entry is replaced.
- R5: Every accepted access makes the entry it hit or filled the most recently used one. A hit therefore protects that entry from the next eviction.
- R6: dump_valid_o and dump_addr_o show, for entry dump_idx_i, its valid bit and the last access address that hit or filled it. The port reflects the update of an access in the cycle after that access.
- R7: Reset clears all valid bits and zeroes both counters. It also sets the recency order to entry 0 as most recent through entry N-1 as least recent.
- R8: hit_count_o and miss_count_o each rise by exactly one together with the matching pulse, and they hold otherwise. They wrap modulo 2^CNT_W.
- R9: A cycle with access_valid_i low changes no entry, no counter and no recency state, and gives no pulse, whatever access_addr_i holds.
- R10: No two valid entries ever hold the same tag, so at most one entry matches a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| access_valid_i | input | 1 | An access is presented this cycle |
| access_addr_i | input | ADDR_W | Byte address of the access |
| hit_o | output | 1 | One-cycle pulse: previous access hit |
| miss_o | output | 1 | One-cycle pulse: previous access missed |
| hit_count_o | output | CNT_W | Number of hits since reset |
| miss_count_o | output | CNT_W | Number of misses since reset |
| dump_idx_i | input | IDX_W | Entry selected for the dump port |
| dump_valid_o | output | 1 | Valid bit of the selected entry |
| dump_addr_o | output | ADDR_W | Last access address of the selected entry |

## Verification
The bench first fills all entries in order and then hits entry 0. The miss that follows must evict entry 1, not entry 0. A design that evicted by slot number or ignored recency refresh would overwrite the wrong entry there, and the dump sweep would show it. It hits on an address at the far end of a block and misses on the first byte of the next block, which catches an off-by-one in the offset shift. Idle cycles with a changing address check that nothing moves without access_valid_i. A long pseudo-random run over a small address window mixes hits, fills and evictions. That run, compared cycle by cycle with a queue model, exposes a broken shift in the recency list or a free-entry search that favours the wrong end.

// File: rtl/fa_lru_pkg.sv
package fa_lru_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_HIT  = 2'd1,
    ACC_MISS = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
  parameter int NUM_ENTRIES = 4,
  parameter int TAG_W       = 13,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [NUM_ENTRIES-1:0]            valid_i,
  input  logic [NUM_ENTRIES-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]                  tag_i,
  output logic [NUM_ENTRIES-1:0]            match_o,
  output logic                              hit_o,
  output logic [IDX_W-1:0]                  hit_idx_o
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  assign hit_o = |match_o;

  // one-hot encode: OR of set positions
  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (match_o[i]) hit_idx_o = hit_idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/fa_victim_select.sv
module fa_victim_select #(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [NUM_ENTRIES-1:0] valid_i,
  input  logic [IDX_W-1:0]       lru_idx_i,
  output logic [IDX_W-1:0]       victim_idx_o
);
  logic             free_found;
  logic [IDX_W-1:0] free_idx;

  // lowest-numbered free entry wins: scan downward so the last write is lowest
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign victim_idx_o = free_found ? free_idx : lru_idx_i;
endmodule

// File: rtl/fa_lru_list.sv
module fa_lru_list #(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] lru_idx_o
);
  // order_q[0] is most recent, order_q[NUM_ENTRIES-1] least recent
  logic [NUM_ENTRIES-1:0][IDX_W-1:0] order_q, order_d;
  logic [NUM_ENTRIES:0]              seen_before;

  assign seen_before[0] = 1'b0;
  assign order_d[0]     = touch_idx_i;

  for (genvar k = 1; k <= NUM_ENTRIES; k++) begin : g_seen
    assign seen_before[k] = seen_before[k-1] || (order_q[k-1] == touch_idx_i);
  end

  // slots up to the touched position shift back; later slots stay
  for (genvar k = 1; k < NUM_ENTRIES; k++) begin : g_shift
    assign order_d[k] = seen_before[k] ? order_q[k] : order_q[k-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_ENTRIES; k++) order_q[k] <= IDX_W'(k);
    end else if (touch_i) begin
      order_q <= order_d;
    end
  end

  assign lru_idx_o = order_q[NUM_ENTRIES-1];

  logic [NUM_ENTRIES-1:0] present;
  always_comb begin
    present = '0;
    for (int k = 0; k < NUM_ENTRIES; k++) present[order_q[k]] = 1'b1;
  end

  // recency list stays a permutation, so the tail names a real entry
  assert_order_perm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &present);

  // the touched entry is at the head after the edge
  assert_touch_front_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> order_q[0] == $past(touch_idx_i));
endmodule

// File: rtl/fa_lru_tracker.sv
module fa_lru_tracker
  import fa_lru_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int NUM_ENTRIES = 4,
  parameter int BLOCK_BYTES = 8,
  parameter int CNT_W       = 16,
  localparam int OFF_W      = $clog2(BLOCK_BYTES),
  localparam int TAG_W      = ADDR_W - OFF_W,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              access_valid_i,
  input  logic [ADDR_W-1:0] access_addr_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic [CNT_W-1:0]  hit_count_o,
  output logic [CNT_W-1:0]  miss_count_o,
  input  logic [IDX_W-1:0]  dump_idx_i,
  output logic              dump_valid_o,
  output logic [ADDR_W-1:0] dump_addr_o
);
  logic [NUM_ENTRIES-1:0]             valid_q;
  logic [NUM_ENTRIES-1:0][TAG_W-1:0]  tag_q;
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]                   hit_cnt_q, miss_cnt_q;
  acc_kind_e                          result_q;

  logic [TAG_W-1:0]       acc_tag;
  logic [NUM_ENTRIES-1:0] match_vec;
  logic                   lookup_hit;
  logic [IDX_W-1:0]       hit_idx, lru_idx, victim_idx, touch_idx;

  assign acc_tag = access_addr_i[ADDR_W-1:OFF_W];

  fa_tag_match #(.NUM_ENTRIES(NUM_ENTRIES), .TAG_W(TAG_W)) i_match (
    .valid_i   (valid_q),
    .tags_i    (tag_q),
    .tag_i     (acc_tag),
    .match_o   (match_vec),
    .hit_o     (lookup_hit),
    .hit_idx_o (hit_idx)
  );

  fa_victim_select #(.NUM_ENTRIES(NUM_ENTRIES)) i_victim (
    .valid_i      (valid_q),
    .lru_idx_i    (lru_idx),
    .victim_idx_o (victim_idx)
  );

  assign touch_idx = lookup_hit ? hit_idx : victim_idx;

  fa_lru_list #(.NUM_ENTRIES(NUM_ENTRIES)) i_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (access_valid_i),
    .touch_idx_i (touch_idx),
    .lru_idx_o   (lru_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= '0;
      tag_q      <= '0;
      addr_q     <= '0;
      hit_cnt_q  <= '0;
      miss_cnt_q <= '0;
      result_q   <= ACC_IDLE;
    end else if (access_valid_i) begin
      valid_q[touch_idx] <= 1'b1;
      tag_q[touch_idx]   <= acc_tag;
      addr_q[touch_idx]  <= access_addr_i;
      if (lookup_hit) begin
        hit_cnt_q <= hit_cnt_q + 1'b1;
        result_q  <= ACC_HIT;
      end else begin
        miss_cnt_q <= miss_cnt_q + 1'b1;
        result_q   <= ACC_MISS;
      end
    end else begin
      result_q <= ACC_IDLE;
    end
  end

  assign hit_o        = (result_q == ACC_HIT);
  assign miss_o       = (result_q == ACC_MISS);
  assign hit_count_o  = hit_cnt_q;
  assign miss_count_o = miss_cnt_q;
  assign dump_valid_o = valid_q[dump_idx_i];
  assign dump_addr_o  = addr_q[dump_idx_i];

  assert_single_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));

  assert_pulse_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access_valid_i |=> !hit_o && !miss_o);

  assert_hit_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> hit_count_o == $past(hit_count_o) + 1'b1);

  assert_miss_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_o |-> $stable(miss_count_o));

  // a missed tag occupies exactly the entry it was written to
  assert_miss_fill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_valid_i && !lookup_hit |=> valid_q[$past(touch_idx)]);
endmodule

// File: tb/test_fa_lru_tracker.sv
`timescale 1ns/10ps
module test_fa_lru_tracker;
  localparam int ADDR_W = 16;
  localparam int N      = 4;
  localparam int BLK    = 8;
  localparam int CNT_W  = 16;
  localparam int OFF    = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              acc_v = 1'b0;
  logic [ADDR_W-1:0] acc_a = '0;
  logic              hit, miss, d_valid;
  logic [CNT_W-1:0]  hcnt, mcnt;
  logic [1:0]        d_idx = '0;
  logic [ADDR_W-1:0] d_addr;

  int total = 0;
  int bad   = 0;

  // model state
  bit m_valid [N];
  int m_addr  [N];
  int m_order [$];
  int m_hits = 0, m_miss = 0;
  bit e_hit = 0, e_miss = 0;

  always #2 clk = ~clk;

  fa_lru_tracker #(.ADDR_W(ADDR_W), .NUM_ENTRIES(N), .BLOCK_BYTES(BLK), .CNT_W(CNT_W))
  i_fa_lru_tracker (
    .clk_i(clk), .rst_ni(rst_n), .access_valid_i(acc_v), .access_addr_i(acc_a),
    .hit_o(hit), .miss_o(miss), .hit_count_o(hcnt), .miss_count_o(mcnt),
    .dump_idx_i(d_idx), .dump_valid_o(d_valid), .dump_addr_o(d_addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_access(input int a);
    int t = a >> OFF;
    int slot = -1;
    for (int j = 0; j < N; j++) if (m_valid[j] && (m_addr[j] >> OFF) == t) slot = j;
    e_hit  = (slot >= 0);
    e_miss = !e_hit;
    if (e_hit) m_hits++;
    else begin
      m_miss++;
      for (int j = N - 1; j >= 0; j--) if (!m_valid[j]) slot = j;
      if (slot < 0) slot = m_order[$];
    end
    m_valid[slot] = 1;
    m_addr[slot]  = a;
    for (int k = 0; k < m_order.size(); k++)
      if (m_order[k] == slot) begin m_order.delete(k); break; end
    m_order.push_front(slot);
  endtask

  task automatic compare_all(input string req);
    int tags [N];
    check(hit === e_hit, {req, " R2 hit_o"}, int'(hit), int'(e_hit));
    check(miss === e_miss, {req, " R2 miss_o"}, int'(miss), int'(e_miss));
    check(int'(hcnt) == (m_hits % 65536), {req, " R8 hit_count"}, int'(hcnt), m_hits);
    check(int'(mcnt) == (m_miss % 65536), {req, " R8 miss_count"}, int'(mcnt), m_miss);
    for (int i = 0; i < N; i++) begin
      d_idx = 2'(i);
      #0.2;
      check(d_valid === m_valid[i], {req, " R6 dump valid"}, int'(d_valid), int'(m_valid[i]));
      if (m_valid[i])
        check(int'(d_addr) == m_addr[i], {req, " R6 dump addr"}, int'(d_addr), m_addr[i]);
      tags[i] = d_valid ? int'(d_addr) >> OFF : -1 - i;
    end
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        check(tags[i] != tags[j], "R10 duplicate tag", tags[i], -1);
  endtask

  task automatic step(input bit v, input int a, input string req);
    @(negedge clk);
    acc_v = v;
    acc_a = ADDR_W'(a);
    if (v) model_access(a);
    else begin e_hit = 0; e_miss = 0; end
    @(posedge clk);
    #0.5;
    acc_v = 1'b0;
    compare_all(req);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed = 12345;
    for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_addr[i] = 0; m_order.push_back(i); end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    #0.5;
    e_hit = 0; e_miss = 0;
    compare_all("R7 reset");

    step(1, 24, "R3 first fill entry 0");
    step(1, 31, "R1 same block hits");
    step(1, 32, "R1 next block misses");
    step(0, 1000, "R9 idle");
    step(0, 8, "R9 idle");
    step(1, 0, "R3 fill");
    step(1, 8, "R3 fill");
    step(1, 30, "R5 hit refresh");
    step(1, 64, "R4 evict lru");
    step(1, 72, "R4 evict lru");
    step(1, 25, "R5 hit");
    step(1, 80, "R4 evict");

    rst_n = 1'b0;
    for (int i = 0; i < N; i++) m_valid[i] = 0;
    m_order.delete();
    for (int i = 0; i < N; i++) m_order.push_back(i);
    m_hits = 0; m_miss = 0;
    #3 rst_n = 1'b1;
    @(posedge clk);
    #0.5;
    e_hit = 0; e_miss = 0;
    compare_all("R7 reset again");
    step(1, 0, "R3 fill");
    step(1, 8, "R3 fill");
    step(1, 16, "R3 fill");
    step(1, 24, "R3 fill");
    step(1, 3, "R5 hit entry 0");
    step(1, 32, "R4 evict entry 1");
    step(1, 11, "R4 entry 1 gone");

    for (int n = 0; n < 400; n++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      step(((seed >> 4) % 5) != 0, (seed >> 8) % 72, "R2 R4 R5 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule